// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold and Interrupt Status

This block buffers 16-bit audio samples between a register port and a serial engine, with one FIFO for each direction. Software writes playback samples into the transmit FIFO, and the serial engine takes them one word at a time. The engine pushes captured words into the receive FIFO, and software reads them back. Each FIFO reports its occupancy and four level flags. Each FIFO also drives a DMA request that compares its occupancy with a 6-bit threshold that software programs.

Starve events (a pop from an empty FIFO), overflow events (a push into a full FIFO) and a word-transferred event are held until software clears them. These sticky events join the live level flags to form thirteen interrupt sources. Each source has its own enable bit. Any enabled source that is active sets a pending bit. The interrupt output is the pending bit gated by a global enable. Writing the clear register drops the pending bit and all sticky events.

Register word addresses: 0 control, 1 transmit data, 2 receive data, 3 interrupt enable, 4 interrupt status, 5 FIFO status, 6 clear. Read data is combinational in the cycle of the read. A read of address 2 with `reg_rd` high pops the receive FIFO at the next clock edge.

Top module: `audio_fifo_ctrl`

## Requirements
- R1: After reset, both FIFOs are empty, the FIFO status word reads 0x0000300C, the interrupt status reads 0x000000C3, and `dma_tx_req`, `dma_rx_req`, `irq` and `tx_word_ok` are low.
- R2: Words written to address 1 (sample in bits 15:0) appear on `tx_word` in write order, with `tx_word_ok` high. Each cycle with `tx_take` high and the FIFO not empty advances to the next word.
- R3: Each cycle with `rx_give` high pushes `rx_word`. A read of address 2 returns bit 16 set with the oldest sample in bits 15:0, and removes that sample. The FIFO status holds the RX count in bits 9:4 and the TX count in bits 19:14.
- R4: A push into a full 32-entry FIFO is dropped, the count stays at 32, and the overflow event latches: TX at status bit 5, RX at status bit 11.
- R5: A read of address 2 while the RX FIFO is empty returns 0, with bit 16 clear, and latches RX starve (status bit 10). `tx_take` on an empty TX FIFO latches TX starve (status bit 4).
- R6: The level flags follow the count: empty when it is 0, almost-empty when it is 4 or less, full when it is 32, almost-full when it is 28 or more. In the FIFO status word the TX flags sit at bits 13, 12, 11, 10 and the RX flags at bits 3, 2, 1, 0, each group in the order empty, almost-empty, full, almost-full.
- R7: `dma_tx_req` is high while control bits 0 (TX enable) and 2 (TX DMA enable) are set and the TX count is at or below the threshold in control bits 18:13.
- R8: `dma_rx_req` is high while control bits 1 (RX enable) and 3 (RX DMA enable) are set and the RX count is at or above the threshold in control bits 12:7.
- R9: When an active source has its bit set in interrupt enable bits 12:0, pending (status bit 13) rises one cycle later. `irq` is high only while pending is set and enable bit 16 is set.
- R10: Any write to address 6 clears pending and every sticky event (bits 4, 5, 10, 11, 12) at the next edge.
- R11: When a direction's enable bit is clear, its FIFO is held empty and pushes and pops on it are ignored: they set no event and change no count.
- R12: A word taken by the engine from the TX FIFO, or pushed by the engine into the RX FIFO, latches the word-transferred event at status bit 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX on address 2) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| tx_take | input | 1 | Engine takes the head TX word |
| tx_word | output | 16 | Head TX sample |
| tx_word_ok | output | 1 | TX FIFO holds a word |
| rx_give | input | 1 | Engine pushes a captured word |
| rx_word | input | 16 | Captured sample |
| dma_tx_req | output | 1 | TX DMA request |
| dma_rx_req | output | 1 | RX DMA request |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with its default parameters: 32-entry FIFOs, an almost-empty level of 4 and an almost-full level of 28. With these values, full, almost-full and the dropped overflow push are reached within about thirty register writes. The TX threshold is set to 4 and the RX threshold to 3, so each DMA request switches at an occupancy that a few pushes reach. The bench checks both sides of each switching point.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
    localparam int SMP_W  = 16;
    localparam int THR_W  = 6;
    localparam int NSRC   = 13;

    // interrupt source positions
    localparam int S_TX_EMPTY  = 0;
    localparam int S_TX_AEMPTY = 1;
    localparam int S_TX_FULL   = 2;
    localparam int S_TX_AFULL  = 3;
    localparam int S_TX_STARVE = 4;
    localparam int S_TX_OVF    = 5;
    localparam int S_RX_EMPTY  = 6;
    localparam int S_RX_AEMPTY = 7;
    localparam int S_RX_FULL   = 8;
    localparam int S_RX_AFULL  = 9;
    localparam int S_RX_STARVE = 10;
    localparam int S_RX_OVF    = 11;
    localparam int S_WORD      = 12;
    localparam logic [NSRC-1:0] STICKY_MASK = 13'b1_1100_0011_0000;

    // register word addresses
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_TXD  = 3'd1;
    localparam logic [2:0] A_RXD  = 3'd2;
    localparam logic [2:0] A_IEN  = 3'd3;
    localparam logic [2:0] A_IST  = 3'd4;
    localparam logic [2:0] A_FST  = 3'd5;
    localparam logic [2:0] A_CLR  = 3'd6;

    typedef struct packed {
        logic [THR_W-1:0] tx_thr;
        logic [THR_W-1:0] rx_thr;
        logic             rx_dma;
        logic             tx_dma;
        logic             rx_en;
        logic             tx_en;
    } ctrl_t;
endpackage

// File: rtl/afifo_store.sv
module afifo_store #(
    parameter int DEPTH  = 32,
    parameter int AE_LVL = 4,
    parameter int AF_LVL = 28,
    parameter int DW     = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          aempty,
    output logic          full,
    output logic          afull,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          ovf_evt,
    output logic          starve_evt
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign count  = st_q.cnt;
    assign empty  = (st_q.cnt == '0);
    assign full   = (st_q.cnt == CW'(DEPTH));
    assign aempty = (st_q.cnt <= CW'(AE_LVL));
    assign afull  = (st_q.cnt >= CW'(AF_LVL));
    assign head   = mem_q[st_q.rp];

    assign push_ok    = en && push && !full;
    assign pop_ok     = en && pop && !empty;
    assign ovf_evt    = en && push && full;
    assign starve_evt = en && pop && empty;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wp = ptr_inc(st_q.wp);
            if (pop_ok)  st_d.rp = ptr_inc(st_q.rp);
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= push_data;
    end

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    assert_drop_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && push && full && !pop) |=> (st_q.cnt == $past(st_q.cnt)));
    assert_flush_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (st_q.cnt == '0));
endmodule

// File: rtl/afifo_irq.sv
module afifo_irq #(
    parameter int              NSRC   = 13,
    parameter logic [NSRC-1:0] STICKY = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] level,
    input  logic [NSRC-1:0] set_evt,
    input  logic            clear,
    input  logic [NSRC-1:0] src_en,
    input  logic            glob_en,
    output logic [NSRC-1:0] status,
    output logic            pending,
    output logic            irq
);
    typedef struct packed {
        logic [NSRC-1:0] sticky;
        logic            pend;
    } st_t;

    st_t st_d, st_q;

    assign status  = (level & ~STICKY) | st_q.sticky;
    assign pending = st_q.pend;
    assign irq     = st_q.pend && glob_en;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            st_d.sticky = st_q.sticky | (set_evt & STICKY);
            st_d.pend   = st_q.pend | (|(status & src_en));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !pending);
    assert_pend_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(status & src_en)) && !clear) |=> pending);

    for (genvar i = 0; i < NSRC; i++) begin : g_hold
        if (STICKY[i]) begin : g_s
            assert_sticky_latch_R12: assert property (@(posedge clk) disable iff (!rst_n)
                (set_evt[i] && !clear) |=> status[i]);
        end
    end
endmodule

// File: rtl/audio_fifo_ctrl.sv
module audio_fifo_ctrl
    import afifo_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int AE_LVL = 4,
    parameter int AF_LVL = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             tx_take,
    output logic [SMP_W-1:0] tx_word,
    output logic             tx_word_ok,
    input  logic             rx_give,
    input  logic [SMP_W-1:0] rx_word,
    output logic             dma_tx_req,
    output logic             dma_rx_req,
    output logic             irq
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        ctrl_t           ctrl;
        logic [NSRC-1:0] ien;
        logic            gie;
    } regs_t;

    regs_t r_d, r_q;

    // index 0 = TX, 1 = RX
    logic [1:0]            f_en, f_push, f_pop;
    logic [1:0][SMP_W-1:0] f_din, f_head;
    logic [1:0][CW-1:0]    f_cnt;
    logic [1:0]            f_empty, f_aempty, f_full, f_afull;
    logic [1:0]            f_push_ok, f_pop_ok, f_ovf, f_starve;

    logic            wr_clear;
    logic [NSRC-1:0] lvl, evt, ist;
    logic            pend;

    assign f_en   = {r_q.ctrl.rx_en, r_q.ctrl.tx_en};
    assign f_push = {rx_give, reg_wr && (reg_addr == A_TXD)};
    assign f_pop  = {reg_rd && (reg_addr == A_RXD), tx_take};
    assign f_din  = {rx_word, reg_wdata[SMP_W-1:0]};

    for (genvar g = 0; g < 2; g++) begin : g_dir
        afifo_store #(
            .DEPTH(DEPTH), .AE_LVL(AE_LVL), .AF_LVL(AF_LVL), .DW(SMP_W)
        ) u_fifo (
            .clk(clk), .rst_n(rst_n), .en(f_en[g]),
            .push(f_push[g]), .push_data(f_din[g]), .pop(f_pop[g]),
            .head(f_head[g]), .count(f_cnt[g]),
            .empty(f_empty[g]), .aempty(f_aempty[g]),
            .full(f_full[g]), .afull(f_afull[g]),
            .push_ok(f_push_ok[g]), .pop_ok(f_pop_ok[g]),
            .ovf_evt(f_ovf[g]), .starve_evt(f_starve[g])
        );
    end

    always_comb begin
        lvl = '0;
        evt = '0;
        lvl[S_TX_EMPTY]  = f_empty[0];
        lvl[S_TX_AEMPTY] = f_aempty[0];
        lvl[S_TX_FULL]   = f_full[0];
        lvl[S_TX_AFULL]  = f_afull[0];
        lvl[S_RX_EMPTY]  = f_empty[1];
        lvl[S_RX_AEMPTY] = f_aempty[1];
        lvl[S_RX_FULL]   = f_full[1];
        lvl[S_RX_AFULL]  = f_afull[1];
        evt[S_TX_STARVE] = f_starve[0];
        evt[S_TX_OVF]    = f_ovf[0];
        evt[S_RX_STARVE] = f_starve[1];
        evt[S_RX_OVF]    = f_ovf[1];
        evt[S_WORD]      = f_pop_ok[0] || f_push_ok[1];
    end

    assign wr_clear = reg_wr && (reg_addr == A_CLR);

    afifo_irq #(.NSRC(NSRC), .STICKY(STICKY_MASK)) u_irq (
        .clk(clk), .rst_n(rst_n), .level(lvl), .set_evt(evt),
        .clear(wr_clear), .src_en(r_q.ien), .glob_en(r_q.gie),
        .status(ist), .pending(pend), .irq(irq)
    );

    always_comb begin
        r_d = r_q;
        if (reg_wr && reg_addr == A_CTRL) begin
            r_d.ctrl.tx_en  = reg_wdata[0];
            r_d.ctrl.rx_en  = reg_wdata[1];
            r_d.ctrl.tx_dma = reg_wdata[2];
            r_d.ctrl.rx_dma = reg_wdata[3];
            r_d.ctrl.rx_thr = reg_wdata[12:7];
            r_d.ctrl.tx_thr = reg_wdata[18:13];
        end
        if (reg_wr && reg_addr == A_IEN) begin
            r_d.ien = reg_wdata[NSRC-1:0];
            r_d.gie = reg_wdata[16];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[0]     = r_q.ctrl.tx_en;
                reg_rdata[1]     = r_q.ctrl.rx_en;
                reg_rdata[2]     = r_q.ctrl.tx_dma;
                reg_rdata[3]     = r_q.ctrl.rx_dma;
                reg_rdata[12:7]  = r_q.ctrl.rx_thr;
                reg_rdata[18:13] = r_q.ctrl.tx_thr;
            end
            A_RXD: if (!f_empty[1]) reg_rdata[16:0] = {1'b1, f_head[1]};
            A_IEN: begin
                reg_rdata[NSRC-1:0] = r_q.ien;
                reg_rdata[16]       = r_q.gie;
            end
            A_IST: reg_rdata[NSRC:0] = {pend, ist};
            A_FST: begin
                reg_rdata[19:14] = 6'(f_cnt[0]);
                reg_rdata[13:10] = {f_empty[0], f_aempty[0], f_full[0], f_afull[0]};
                reg_rdata[9:4]   = 6'(f_cnt[1]);
                reg_rdata[3:0]   = {f_empty[1], f_aempty[1], f_full[1], f_afull[1]};
            end
            default: reg_rdata = '0;
        endcase
    end

    assign tx_word    = f_head[0];
    assign tx_word_ok = !f_empty[0];
    assign dma_tx_req = r_q.ctrl.tx_en && r_q.ctrl.tx_dma &&
                        (int'(f_cnt[0]) <= int'(r_q.ctrl.tx_thr));
    assign dma_rx_req = r_q.ctrl.rx_en && r_q.ctrl.rx_dma &&
                        (int'(f_cnt[1]) >= int'(r_q.ctrl.rx_thr));

    assert_rx_dma_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rx_req && r_q.ctrl.rx_thr != '0) |-> !f_empty[1]);
    assert_tx_word_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_word_ok && tx_take) |-> dma_tx_req || !r_q.ctrl.tx_dma ||
        (int'(f_cnt[0]) > int'(r_q.ctrl.tx_thr)));
endmodule

// File: tb/audio_fifo_ctrl_tb.sv
module audio_fifo_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_take = 1'b0;
    logic [15:0] tx_word;
    logic        tx_word_ok;
    logic        rx_give = 1'b0;
    logic [15:0] rx_word = '0;
    logic        dma_tx_req, dma_rx_req, irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    audio_fifo_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_take(tx_take), .tx_word(tx_word), .tx_word_ok(tx_word_ok),
        .rx_give(rx_give), .rx_word(rx_word),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req), .irq(irq)
    );

    typedef struct packed {
        logic        rd;
        logic [2:0]  addr;
        logic [31:0] data;
    } vec_t;

    // control: tx_en|rx_en|tx_dma|rx_dma, rx thr 3 (12:7), tx thr 4 (18:13)
    localparam vec_t VEC [11] = '{
        '{1'b0, 3'd0, 32'h0000_818F},
        '{1'b1, 3'd0, 32'h0000_818F},
        '{1'b0, 3'd1, 32'h0000_1111},
        '{1'b0, 3'd1, 32'h0000_2222},
        '{1'b0, 3'd1, 32'h0000_3333},
        '{1'b1, 3'd5, 32'h0000_D00C},
        '{1'b1, 3'd4, 32'h0000_00C2},
        '{1'b1, 3'd2, 32'h0000_0000},
        '{1'b1, 3'd4, 32'h0000_04C2},
        '{1'b0, 3'd6, 32'h0000_0000},
        '{1'b1, 3'd4, 32'h0000_00C2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = (a == 3'd2);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic take();
        @(negedge clk);
        tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
    endtask

    task automatic give(input logic [15:0] w);
        @(negedge clk);
        rx_give = 1'b1; rx_word = w;
        @(negedge clk);
        rx_give = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd5, v); chk("R1 fifo status", v, 32'h0000_300C);
        rd(3'd4, v); chk("R1 irq status", v, 32'h0000_00C3);
        chk("R1 outputs", {28'b0, dma_tx_req, dma_rx_req, irq, tx_word_ok}, 32'h0);

        // table walk: R6, R5 starve, R10 clear
        for (int i = 0; i < 11; i++) begin
            if (VEC[i].rd) begin
                rd(VEC[i].addr, v);
                chk($sformatf("R6/R5/R10 vector %0d", i), v, VEC[i].data);
            end else begin
                wr(VEC[i].addr, VEC[i].data);
            end
        end

        // R2 order through engine side
        chk("R2 head first", {15'b0, tx_word_ok, tx_word}, 32'h0001_1111);
        take();
        chk("R2 head second", {15'b0, tx_word_ok, tx_word}, 32'h0001_2222);
        rd(3'd4, v); chk("R12 word event", {31'b0, v[12]}, 32'h1);
        chk("R7 dma at count 2", {31'b0, dma_tx_req}, 32'h1);

        // R7 threshold boundary (thr 4)
        wr(3'd1, 32'h4444); wr(3'd1, 32'h5555);
        chk("R7 dma at count 4", {31'b0, dma_tx_req}, 32'h1);
        wr(3'd1, 32'h6666);
        chk("R7 dma off at count 5", {31'b0, dma_tx_req}, 32'h0);

        // R6 almost-full boundary, R4 overflow
        for (int k = 5; k < 27; k++) wr(3'd1, 32'(k));
        rd(3'd5, v); chk("R6 count 27 not afull", {26'b0, v[19:14]}, 32'd27);
        chk("R6 afull clear at 27", {31'b0, v[10]}, 32'h0);
        wr(3'd1, 32'h0);
        rd(3'd5, v); chk("R6 afull at 28", {31'b0, v[10]}, 32'h1);
        for (int k = 28; k < 32; k++) wr(3'd1, 32'(k));
        rd(3'd5, v); chk("R6 full at 32", {26'b0, v[19:14], v[11:10]}, {24'b0, 6'd32, 2'b11});
        rd(3'd4, v); chk("R4 no overflow yet", {31'b0, v[5]}, 32'h0);
        wr(3'd1, 32'hBEEF);
        rd(3'd5, v); chk("R4 count held", {26'b0, v[19:14]}, 32'd32);
        rd(3'd4, v); chk("R4 overflow latched", {31'b0, v[5]}, 32'h1);

        // R3 / R8 receive path (thr 3)
        give(16'h00A1); give(16'h00A2);
        chk("R8 below thr", {31'b0, dma_rx_req}, 32'h0);
        give(16'h00A3);
        chk("R8 at thr", {31'b0, dma_rx_req}, 32'h1);
        rd(3'd2, v); chk("R3 rx read", v, 32'h0001_00A1);
        chk("R8 off after pop", {31'b0, dma_rx_req}, 32'h0);
        rd(3'd5, v); chk("R3 rx count", {26'b0, v[9:4]}, 32'd2);
        chk("R6 rx aempty", {28'b0, v[3:0]}, 32'h4);

        // R9 pending and gating
        wr(3'd6, 32'h0);
        wr(3'd3, 32'h0000_1000);
        take();
        @(negedge clk);
        rd(3'd4, v); chk("R9 pending set", {31'b0, v[13]}, 32'h1);
        chk("R9 irq gated off", {31'b0, irq}, 32'h0);
        wr(3'd3, 32'h0001_1000);
        chk("R9 irq on", {31'b0, irq}, 32'h1);

        // R10 clear
        wr(3'd6, 32'h0);
        rd(3'd4, v); chk("R10 cleared", {30'b0, v[13:12]}, 32'h0);
        chk("R10 irq low", {31'b0, irq}, 32'h0);

        // R11 direction disable
        wr(3'd0, 32'h0000_818E);
        rd(3'd5, v); chk("R11 tx flushed", {26'b0, v[19:14]}, 32'd0);
        wr(3'd1, 32'h7777);
        rd(3'd5, v); chk("R11 write ignored", {26'b0, v[19:14]}, 32'd0);
        rd(3'd4, v); chk("R11 no overflow", {31'b0, v[5]}, 32'h0);
        chk("R11 no word", {31'b0, tx_word_ok}, 32'h0);

        // R5 engine starve on empty TX
        wr(3'd0, 32'h0000_818F);
        take();
        rd(3'd4, v); chk("R5 tx starve", {31'b0, v[4]}, 32'h1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule